// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block is the power-management controller of a chip. It moves the chip between its running state, a light idle state and a deep stop state. Software writes a mode register that holds an idle bit and a stop bit, a configuration bit that can keep the crystal oscillator running while stopped, and a vector of per-block clock enables. The sequencer turns those writes into clock-enable outputs and into request/acknowledge handshakes with the bus and memory controllers. It also drives the PLL and oscillator enables and selects the system clock source. A deeper power-domain sleep mode is not supported.

Idle only gates the CPU clock, and any enabled interrupt ends it. Stop is an ordered chain of steps. First the bus is drained. Then the SDRAM is placed in self-refresh. Then the system and CPU clocks are gated and the clock source is moved to the PLL reference. Last, the PLL and the oscillator are shut off. Any of the wake sources brings the chip back. On the way back, the oscillator and PLL are turned on again, two fixed wait counts run (oscillator settle, then PLL lock), self-refresh is released, and only then do the clocks come back. The mode bits stay set until software clears them, and a bit must be written from 0 to 1 to start its mode again.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, seqState is 0 (NORMAL), cpuClkEn, sysClkEn, pllEn and oscEn are 1, clkSrcRef, busDrainReq and srefReq are 0, modeBits is 0, and every blkClkEn bit is 1. State codes: 0 NORMAL, 1 IDLE, 2 DRAIN, 3 SREF_IN, 4 CLK_OFF, 5 STOPPED, 6 SETTLE, 7 LOCK, 8 SREF_OUT.
- R2: In NORMAL, a gateWrEn write sets blkClkEn to gateWrData from the next cycle on. While sysClkEn is 0, every blkClkEn bit is 0.
- R3: In NORMAL, a modeBits write that takes bit 0 (idle) from 0 to 1 enters IDLE on the next cycle. In IDLE, cpuClkEn is 0 and every other clock and the PLL and oscillator stay enabled.
- R4: In NORMAL, a write that takes modeBits bit 1 (stop) from 0 to 1 enters DRAIN on the next cycle and raises busDrainReq. srefReq stays 0 until busDrainAck is seen.
- R5: busDrainAck in DRAIN moves to SREF_IN and raises srefReq. The clocks stay on until srefAck is seen.
- R6: srefAck in SREF_IN moves to CLK_OFF. There sysClkEn and cpuClkEn drop to 0 and clkSrcRef rises to 1.
- R7: One cycle after CLK_OFF the block is in STOPPED, with pllEn at 0 and oscEn equal to the stored keep-oscillator bit (cfgWrData).
- R8: In STOPPED, any single bit of wakeSrc moves to SETTLE on the next cycle, and pllEn and oscEn go back to 1. wakeSrc has no effect in NORMAL.
- R9: SETTLE lasts exactly SETTLE_CYC cycles and LOCK then lasts exactly LOCK_CYC cycles. sysClkEn and cpuClkEn stay 0 throughout.
- R10: After LOCK, SREF_OUT drops srefReq and clkSrcRef and keeps the clocks off until srefAck is low. On the next cycle the block returns to NORMAL with all clocks enabled and busDrainReq at 0.
- R11: Hardware never clears modeBits. Writing a mode bit that is already 1 starts no mode.
- R12: In IDLE, irqPending returns to NORMAL on the next cycle with cpuClkEn at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Write strobe for the mode register |
| modeWrData | input | 2 | Mode value: bit 0 idle, bit 1 stop |
| cfgWrEn | input | 1 | Write strobe for the keep-oscillator bit |
| cfgWrData | input | 1 | Keep oscillator running while stopped |
| gateWrEn | input | 1 | Write strobe for the per-block clock enables |
| gateWrData | input | NUM_BLK | Per-block clock enable value |
| irqPending | input | 1 | Any enabled interrupt pending (idle exit) |
| wakeSrc | input | NUM_WAKE | Stop wake sources: external IRQ, RTC alarm, RTC tick, battery fault |
| busDrainAck | input | 1 | Bus controller has finished pending transfers |
| srefAck | input | 1 | Memory controller is in self-refresh |
| busDrainReq | output | 1 | Request the bus controller to drain |
| srefReq | output | 1 | Request self-refresh from the memory controller |
| cpuClkEn | output | 1 | CPU clock enable |
| sysClkEn | output | 1 | System clock enable |
| blkClkEn | output | NUM_BLK | Per-block clock enables |
| clkSrcRef | output | 1 | 1 selects the PLL reference as the system clock source |
| pllEn | output | 1 | PLL enable |
| oscEn | output | 1 | Crystal oscillator enable |
| modeBits | output | 2 | Current mode register value |
| seqState | output | 4 | Sequencer state code |

## Verification
The assertions assume that the bus and memory controllers behave as well-formed handshake partners. An acknowledge is raised only while its request is high, and srefAck is lowered only after srefReq has fallen. The bench models both controllers with these rules. It raises each acknowledge after a chosen delay and drops it only once the sequencer has released the request. wakeSrc and irqPending are pulsed for one cycle and only in the states where they have a defined effect. The exception is a deliberate wake pulse in NORMAL, which checks that it has no effect.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_NORMAL   = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DRAIN    = 4'd2,
    ST_SREF_IN  = 4'd3,
    ST_CLK_OFF  = 4'd4,
    ST_STOPPED  = 4'd5,
    ST_SETTLE   = 4'd6,
    ST_LOCK     = 4'd7,
    ST_SREF_OUT = 4'd8
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cpuOn;
    logic sysOn;
    logic srcRef;
    logic pllOn;
    logic oscForce;
    logic busReq;
    logic srefReq;
    logic ldSettle;
    logic ldLock;
    logic decCnt;
  } pwrStrobe_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleSet,
  input  logic       stopSet,
  input  logic       irqPending,
  input  logic       wakeAny,
  input  logic       busAck,
  input  logic       srefAck,
  input  logic       cntZero,
  output pwrStrobe_t stb,
  output pwrState_e  st
);

  pwrState_e nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_NORMAL;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    stb.cpuOn    = 1'b1;
    stb.sysOn    = 1'b1;
    stb.pllOn    = 1'b1;
    stb.oscForce = 1'b1;
    unique case (st)
      ST_NORMAL: begin
        if (stopSet)      nxt = ST_DRAIN;
        else if (idleSet) nxt = ST_IDLE;
      end
      ST_IDLE: begin
        stb.cpuOn = 1'b0;
        if (irqPending) nxt = ST_NORMAL;
      end
      ST_DRAIN: begin
        stb.busReq = 1'b1;
        if (busAck) nxt = ST_SREF_IN;
      end
      ST_SREF_IN: begin
        stb.busReq  = 1'b1;
        stb.srefReq = 1'b1;
        if (srefAck) nxt = ST_CLK_OFF;
      end
      ST_CLK_OFF: begin
        stb.cpuOn = 1'b0; stb.sysOn = 1'b0; stb.srcRef = 1'b1;
        stb.busReq = 1'b1; stb.srefReq = 1'b1;
        nxt = ST_STOPPED;
      end
      ST_STOPPED: begin
        stb.cpuOn = 1'b0; stb.sysOn = 1'b0; stb.srcRef = 1'b1;
        stb.busReq = 1'b1; stb.srefReq = 1'b1;
        stb.pllOn = 1'b0; stb.oscForce = 1'b0;
        if (wakeAny) begin
          nxt = ST_SETTLE;
          stb.ldSettle = 1'b1;
        end
      end
      ST_SETTLE, ST_LOCK: begin
        stb.cpuOn = 1'b0; stb.sysOn = 1'b0; stb.srcRef = 1'b1;
        stb.busReq = 1'b1; stb.srefReq = 1'b1;
        if (!cntZero) stb.decCnt = 1'b1;
        else if (st == ST_SETTLE) begin
          nxt = ST_LOCK;
          stb.ldLock = 1'b1;
        end else nxt = ST_SREF_OUT;
      end
      ST_SREF_OUT: begin
        stb.cpuOn = 1'b0; stb.sysOn = 1'b0;
        stb.busReq = 1'b1;
        if (!srefAck) nxt = ST_NORMAL;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  // R5: self-refresh is requested only after the bus drained
  a_r5_sref_after_bus: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.srefReq) |-> $past(busAck));

  // R6: clocks drop only after the self-refresh acknowledge
  a_r6_clk_after_sref: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.sysOn) |-> ($past(srefAck) && stb.srcRef));

  // R8: a wake in STOPPED starts the settle wait
  a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_STOPPED && wakeAny) |=> (st == ST_SETTLE));

  // R10: clocks return only once self-refresh has been released
  a_r10_release_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.sysOn) |-> !$past(srefAck));

endmodule

// File: rtl/pwr_seq_dpath.sv
module pwr_seq_dpath
  import pwr_seq_pkg::*;
#(
  parameter int NUM_BLK    = 4,
  parameter int NUM_WAKE   = 4,
  parameter int SETTLE_CYC = 16,
  parameter int LOCK_CYC   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwrStrobe_t          stb,
  input  logic                modeWrEn,
  input  logic [1:0]          modeWrData,
  input  logic                cfgWrEn,
  input  logic                cfgWrData,
  input  logic                gateWrEn,
  input  logic [NUM_BLK-1:0]  gateWrData,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  output logic                idleSet,
  output logic                stopSet,
  output logic                wakeAny,
  output logic                cntZero,
  output logic                cpuClkEn,
  output logic                sysClkEn,
  output logic [NUM_BLK-1:0]  blkClkEn,
  output logic                clkSrcRef,
  output logic                pllEn,
  output logic                oscEn,
  output logic                busDrainReq,
  output logic                srefReq,
  output logic [1:0]          modeBits
);

  localparam int MAX_CYC = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LD   = CNT_W'(LOCK_CYC - 1);

  logic [1:0]         modeReg;
  logic               keepOsc;
  logic [NUM_BLK-1:0] gateReg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      keepOsc <= 1'b0;
      gateReg <= '1;
    end else begin
      if (modeWrEn) modeReg <= modeWrData;
      if (cfgWrEn)  keepOsc <= cfgWrData;
      if (gateWrEn) gateReg <= gateWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (stb.ldSettle)         cnt <= SETTLE_LD;
    else if (stb.ldLock)           cnt <= LOCK_LD;
    else if (stb.decCnt && cnt != '0) cnt <= cnt - 1'b1;
  end

  // a mode starts only on a 0 -> 1 write of its bit
  assign idleSet = modeWrEn & modeWrData[0] & ~modeReg[0];
  assign stopSet = modeWrEn & modeWrData[1] & ~modeReg[1];
  assign wakeAny = |wakeSrc;
  assign cntZero = (cnt == '0);

  assign cpuClkEn    = stb.cpuOn;
  assign sysClkEn    = stb.sysOn;
  assign clkSrcRef   = stb.srcRef;
  assign pllEn       = stb.pllOn;
  assign oscEn       = stb.oscForce | keepOsc;
  assign busDrainReq = stb.busReq;
  assign srefReq     = stb.srefReq;
  assign modeBits    = modeReg;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_gate
    assign blkClkEn[g] = gateReg[g] & stb.sysOn;
  end

  // R2: a gate write lands in the register on the next cycle
  a_r2_gate_next: assert property (@(posedge clk) disable iff (!rstN)
    $past(gateWrEn) |-> (gateReg == $past(gateWrData)));

  // R9: the wait counter never exceeds its largest load
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_CYC - 1));

  // R11: hardware never changes the mode bits without a write
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modeWrEn) |-> $stable(modeReg));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_BLK    = 4,
  parameter int NUM_WAKE   = 4,
  parameter int SETTLE_CYC = 16,
  parameter int LOCK_CYC   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWrEn,
  input  logic [1:0]          modeWrData,
  input  logic                cfgWrEn,
  input  logic                cfgWrData,
  input  logic                gateWrEn,
  input  logic [NUM_BLK-1:0]  gateWrData,
  input  logic                irqPending,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic                busDrainAck,
  input  logic                srefAck,
  output logic                busDrainReq,
  output logic                srefReq,
  output logic                cpuClkEn,
  output logic                sysClkEn,
  output logic [NUM_BLK-1:0]  blkClkEn,
  output logic                clkSrcRef,
  output logic                pllEn,
  output logic                oscEn,
  output logic [1:0]          modeBits,
  output logic [3:0]          seqState
);

  pwrStrobe_t stb;
  pwrState_e  st;
  logic idleSet, stopSet, wakeAny, cntZero;

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .idleSet(idleSet), .stopSet(stopSet),
    .irqPending(irqPending), .wakeAny(wakeAny), .busAck(busDrainAck),
    .srefAck(srefAck), .cntZero(cntZero), .stb(stb), .st(st)
  );

  pwr_seq_dpath #(
    .NUM_BLK(NUM_BLK), .NUM_WAKE(NUM_WAKE),
    .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .gateWrEn(gateWrEn), .gateWrData(gateWrData), .wakeSrc(wakeSrc),
    .idleSet(idleSet), .stopSet(stopSet), .wakeAny(wakeAny), .cntZero(cntZero),
    .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn), .blkClkEn(blkClkEn),
    .clkSrcRef(clkSrcRef), .pllEn(pllEn), .oscEn(oscEn),
    .busDrainReq(busDrainReq), .srefReq(srefReq), .modeBits(modeBits)
  );

  assign seqState = st;

endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;

  localparam int NUM_BLK = 4;
  localparam int NUM_WAKE = 4;
  localparam int SETTLE_CYC = 16;
  localparam int LOCK_CYC = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 0, cfgWrEn = 0, cfgWrData = 0, gateWrEn = 0;
  logic [1:0] modeWrData = '0;
  logic [NUM_BLK-1:0] gateWrData = '0;
  logic irqPending = 0, busDrainAck = 0, srefAck = 0;
  logic [NUM_WAKE-1:0] wakeSrc = '0;
  logic busDrainReq, srefReq, cpuClkEn, sysClkEn, clkSrcRef, pllEn, oscEn;
  logic [NUM_BLK-1:0] blkClkEn;
  logic [1:0] modeBits;
  logic [3:0] seqState;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.NUM_BLK(NUM_BLK), .NUM_WAKE(NUM_WAKE),
                 .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)) dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .gateWrEn(gateWrEn),
    .gateWrData(gateWrData), .irqPending(irqPending), .wakeSrc(wakeSrc),
    .busDrainAck(busDrainAck), .srefAck(srefAck), .busDrainReq(busDrainReq),
    .srefReq(srefReq), .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn),
    .blkClkEn(blkClkEn), .clkSrcRef(clkSrcRef), .pllEn(pllEn), .oscEn(oscEn),
    .modeBits(modeBits), .seqState(seqState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [1:0] v);
    modeWrEn = 1'b1; modeWrData = v;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  task automatic stopCycle(input logic keep, input int w, input int busDly, input int srefDly);
    int n;
    cfgWrEn = 1'b1; cfgWrData = keep;
    @(negedge clk);
    cfgWrEn = 1'b0;
    writeMode(2'b00);
    writeMode(2'b10);
    chk("R4 state drain", seqState, 2);
    chk("R4 busDrainReq", busDrainReq, 1);
    for (int i = 0; i < busDly; i++) begin
      @(negedge clk);
      chk("R4 no sref before bus ack", srefReq, 0);
    end
    busDrainAck = 1'b1;
    @(negedge clk);
    chk("R5 state sref_in", seqState, 3);
    chk("R5 srefReq", srefReq, 1);
    for (int i = 0; i < srefDly; i++) begin
      @(negedge clk);
      chk("R5 clocks on before sref ack", sysClkEn, 1);
    end
    srefAck = 1'b1;
    @(negedge clk);
    chk("R6 state clk_off", seqState, 4);
    chk("R6 sysClkEn", sysClkEn, 0);
    chk("R6 cpuClkEn", cpuClkEn, 0);
    chk("R6 clkSrcRef", clkSrcRef, 1);
    @(negedge clk);
    chk("R7 state stopped", seqState, 5);
    chk("R7 pllEn", pllEn, 0);
    chk("R7 oscEn keep", oscEn, int'(keep));
    chk("R2 blk gated in stop", blkClkEn, 0);
    @(negedge clk);
    chk("R8 stays stopped without wake", seqState, 5);
    wakeSrc = NUM_WAKE'(1) << w;
    @(negedge clk);
    wakeSrc = '0;
    chk("R8 state settle", seqState, 6);
    chk("R8 pllEn", pllEn, 1);
    chk("R8 oscEn", oscEn, 1);
    n = 0;
    while (seqState == 6) begin
      n++;
      if (sysClkEn || cpuClkEn) chk("R9 clocks off in settle", 1, 0);
      @(negedge clk);
    end
    chk("R9 settle length", n, SETTLE_CYC);
    n = 0;
    while (seqState == 7) begin
      n++;
      if (sysClkEn || cpuClkEn) chk("R9 clocks off in lock", 1, 0);
      @(negedge clk);
    end
    chk("R9 lock length", n, LOCK_CYC);
    chk("R10 state sref_out", seqState, 8);
    chk("R10 srefReq dropped", srefReq, 0);
    chk("R10 clkSrcRef back", clkSrcRef, 0);
    @(negedge clk);
    chk("R10 waits for release", seqState, 8);
    chk("R10 clocks off while held", sysClkEn, 0);
    srefAck = 1'b0;
    @(negedge clk);
    chk("R10 state normal", seqState, 0);
    chk("R10 sysClkEn", sysClkEn, 1);
    chk("R10 cpuClkEn", cpuClkEn, 1);
    chk("R10 busDrainReq", busDrainReq, 0);
    busDrainAck = 1'b0;
    chk("R11 stop bit kept", modeBits, 2);
    writeMode(2'b10);
    chk("R11 rewrite of set bit ignored", seqState, 0);
  endtask

  initial begin
    #(20 * 190000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 state", seqState, 0);
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 sysClkEn", sysClkEn, 1);
    chk("R1 pllEn", pllEn, 1);
    chk("R1 oscEn", oscEn, 1);
    chk("R1 clkSrcRef", clkSrcRef, 0);
    chk("R1 reqs", {busDrainReq, srefReq}, 0);
    chk("R1 modeBits", modeBits, 0);
    chk("R1 blkClkEn", blkClkEn, 15);

    // R2: every gate pattern
    for (int v = 0; v < (1 << NUM_BLK); v++) begin
      gateWrEn = 1'b1; gateWrData = NUM_BLK'(v);
      @(negedge clk);
      gateWrEn = 1'b0;
      chk("R2 blkClkEn", blkClkEn, v);
    end

    // R8: wake has no effect in NORMAL
    wakeSrc = '1;
    @(negedge clk);
    wakeSrc = '0;
    chk("R8 wake ignored in normal", seqState, 0);

    // R3 / R12 / R11: idle
    writeMode(2'b01);
    chk("R3 state idle", seqState, 1);
    chk("R3 cpuClkEn", cpuClkEn, 0);
    chk("R3 sysClkEn", sysClkEn, 1);
    chk("R3 pll/osc", {pllEn, oscEn}, 3);
    repeat (3) @(negedge clk);
    chk("R12 stays idle without irq", seqState, 1);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    chk("R12 state normal", seqState, 0);
    chk("R12 cpuClkEn", cpuClkEn, 1);
    chk("R11 idle bit kept", modeBits, 1);
    writeMode(2'b01);
    chk("R11 idle rewrite ignored", seqState, 0);
    writeMode(2'b00);
    writeMode(2'b01);
    chk("R11 idle re-armed", seqState, 1);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;

    // stop sweep: keep bit x each wake source
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < NUM_WAKE; w++)
        stopCycle(k[0], w, w, 3 - w);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule